// File: doc/BRIEF.md
# Single-Channel Copy/Fill DMA Engine

The block is one DMA channel that software programs through a 32-bit register port. Once enabled, it either copies a run of 32-bit words from a source region to a destination region, or writes one 32-bit pattern value into every word of a destination region. It reaches memory through a single word-wide master port. That port carries a request, a write flag, a 40-bit byte address, write data and read data, and a ready handshake.

Each 40-bit address is built from a 32-bit low pointer register and an 8-bit field of a shared high-address register. Software programs the length as the word count minus one. An access-control register gates the channel. When it is closed, an enable attempt is turned away and reported as an error instead of reaching memory.

Software polls a busy flag or waits for a maskable level interrupt. It can stop a transfer at any moment by writing zero to the control register.

Top module: `cpfill_dma`

## Requirements
- R1: After reset, every register reads 0, the request output is low and the interrupt is low.
- R2: In copy mode (mode field bits [23:21] = 4), each word is first read from the source and then written to the destination. There is only one request outstanding at a time, and a write always follows a read before the next read is issued.
- R3: Source address = {high register bits [7:0], source pointer}. Destination address = {high register bits [23:16], destination pointer}. Both addresses advance by 4 bytes per word, and a carry out of the low 32 bits propagates into the upper 8 bits.
- R4: The word count register (offset 0x20) holds N-1. A value of 0 moves exactly one word.
- R5: In fill mode (mode field = 6), the channel issues only writes. Every destination word receives the pattern register value (offset 0x34) as it stood when the channel was enabled.
- R6: Writing the enable bit (control bit 31, offset 0x0) while the access register (offset 0x38) is non-zero issues no memory request. It sets sticky error status bit 0 and leaves control bit 31 at 0. Writing 1 to status bit 0 clears it.
- R7: When the last write is accepted, busy (status bit 31, offset 0x4) drops and done (status bit 30) is set. Writing 1 to bit 30 clears done. The irq output equals done AND control bit 15.
- R8: Writing a control value with bit 31 clear during a transfer drops the request on the next cycle, clears busy, and issues no further memory access.
- R9: Enabling with a mode field other than 4 or 6 behaves like a blocked start: no request, error bit 0 set, enable left at 0.
- R10: While a request waits for ready, the master holds address, write data and the write flag steady.
- R11: Status bit 31 reads 1 from the cycle after the enabling write until the last write is accepted.
- R12: With run-once (control bit 27) set, completion clears control bit 31. With it clear, control bit 31 stays 1 after completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr (combinational) |
| memReq | output | 1 | Memory request valid |
| memWrite | output | 1 | 1 = write, 0 = read |
| memAddr | output | 40 | Byte address of the current word |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, captured when ready is high on a read |
| memReady | input | 1 | Memory accepts the current request |
| irq | output | 1 | Level completion interrupt |

## Verification
On every cycle, properties check the handshake rules:
- request, address, data and write flag hold while ready is low;
- in copy mode, an accepted read is always followed by a write;
- a blocked or stopping control write leaves the request low on the next cycle;
- completion drops the request.

Only the scenarios can show the data path is right. A scoreboard compares every accepted access against the expected order of addresses, including the carry into the upper address bits and the N-1 length encoding. It also covers the pattern value, the sticky error and done bits and their clearing, the masking of the interrupt, and the run-once effect on the enable bit.

// File: rtl/cpfill_pkg.sv
package cpfill_pkg;
  localparam int DATA_W = 32;
  localparam int HI_W   = 8;
  localparam int ADDR_W = DATA_W + HI_W;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_SRC  = 8'h0C;
  localparam logic [7:0] OFS_DST  = 8'h10;
  localparam logic [7:0] OFS_HI   = 8'h14;
  localparam logic [7:0] OFS_CNT  = 8'h20;
  localparam logic [7:0] OFS_PAT  = 8'h34;
  localparam logic [7:0] OFS_ACC  = 8'h38;

  localparam int BIT_EN    = 31;
  localparam int BIT_ONCE  = 27;
  localparam int BIT_IRQEN = 15;
  localparam int MODE_LSB  = 21;

  localparam logic [2:0] MODE_COPY = 3'd4;
  localparam logic [2:0] MODE_FILL = 3'd6;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} chanState_t;

  typedef struct packed {
    logic loadPtrs;
    logic captureRd;
    logic stepWord;
    logic finish;
    logic reject;
  } dpStrobe_t;
endpackage

// File: rtl/cpfill_ctrl.sv
module cpfill_ctrl
  import cpfill_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      goReq,
  input  logic      stopReq,
  input  logic [2:0] wrMode,
  input  logic      accessOpen,
  input  logic      lastWord,
  input  logic      memReady,
  output dpStrobe_t stb,
  output logic      memReq,
  output logic      memWrite
);
  chanState_t state, nextState;
  logic fillRun, nextFill;
  logic modeOk;

  assign modeOk = (wrMode == MODE_COPY) || (wrMode == MODE_FILL);

  always_comb begin
    stb       = '0;
    nextState = state;
    nextFill  = fillRun;
    if (stopReq) begin
      nextState = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (goReq) begin
            if (!accessOpen || !modeOk) begin
              stb.reject = 1'b1;
            end else begin
              stb.loadPtrs = 1'b1;
              nextFill     = (wrMode == MODE_FILL);
              nextState    = (wrMode == MODE_FILL) ? ST_WRITE : ST_READ;
            end
          end
        end
        ST_READ: begin
          if (memReady) begin
            stb.captureRd = 1'b1;
            nextState     = ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (memReady) begin
            if (lastWord) begin
              stb.finish = 1'b1;
              nextState  = ST_IDLE;
            end else begin
              stb.stepWord = 1'b1;
              nextState    = fillRun ? ST_WRITE : ST_READ;
            end
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      fillRun <= 1'b0;
    end else begin
      state   <= nextState;
      fillRun <= nextFill;
    end
  end

  assign memReq   = (state != ST_IDLE);
  assign memWrite = (state == ST_WRITE);

  // R2: an accepted copy read is always followed by a write request
  a_r2_read_then_write: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWrite && memReady && !stopReq) |=> (memReq && memWrite));

  // R6 and R9: a rejected start issues no request
  a_r6_blocked_start: assert property (@(posedge clk) disable iff (!rstN)
    (!memReq && goReq && (!accessOpen || !modeOk)) |=> !memReq);

  // R8: a stop write idles the master on the next cycle
  a_r8_stop_idles: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> !memReq);

  // R10: a waiting request and its direction are held
  a_r10_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady && !stopReq) |=> (memReq && $stable(memWrite)));

  // R7: completion drops the request
  a_r7_finish_idles: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish |=> !memReq);
endmodule

// File: rtl/cpfill_dpath.sv
module cpfill_dpath
  import cpfill_pkg::*;
#(
  parameter int CNT_W = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [7:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  dpStrobe_t         stb,
  input  logic              busy,
  input  logic              memWrite,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              irq,
  output logic              goReq,
  output logic              stopReq,
  output logic [2:0]        wrMode,
  output logic              accessOpen,
  output logic              lastWord
);
  localparam int PAD_W = DATA_W - CNT_W;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic [DATA_W-1:0] ctrlReg, srcLo, dstLo, patReg;
  logic [HI_W-1:0]   srcHi, dstHi;
  logic [CNT_W-1:0]  wordCnt, remaining;
  logic [1:0]        accessReg;
  logic              errFlag, doneFlag;
  logic [ADDR_W-1:0] srcCur, dstCur;
  logic [DATA_W-1:0] dataBuf;
  logic              ctrlWr, statWr;

  assign ctrlWr     = regWr && (regAddr == OFS_CTRL);
  assign statWr     = regWr && (regAddr == OFS_STAT);
  assign goReq      = ctrlWr && regWdata[BIT_EN];
  assign stopReq    = ctrlWr && !regWdata[BIT_EN];
  assign wrMode     = regWdata[MODE_LSB +: 3];
  assign accessOpen = (accessReg == 2'd0);
  assign lastWord   = (remaining == '0);

  // programmable registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      srcLo     <= '0;
      dstLo     <= '0;
      srcHi     <= '0;
      dstHi     <= '0;
      wordCnt   <= '0;
      patReg    <= '0;
      accessReg <= '0;
    end else begin
      if (stb.reject)
        ctrlReg <= {1'b0, regWdata[DATA_W-2:0]};
      else if (stb.finish && ctrlReg[BIT_ONCE])
        ctrlReg[BIT_EN] <= 1'b0;
      else if (ctrlWr && !(busy && regWdata[BIT_EN]))
        ctrlReg <= regWdata;
      if (regWr) begin
        case (regAddr)
          OFS_SRC: srcLo <= regWdata;
          OFS_DST: dstLo <= regWdata;
          OFS_HI: begin
            srcHi <= regWdata[HI_W-1:0];
            dstHi <= regWdata[16 +: HI_W];
          end
          OFS_CNT: wordCnt   <= regWdata[CNT_W-1:0];
          OFS_PAT: patReg    <= regWdata;
          OFS_ACC: accessReg <= regWdata[1:0];
          default: ;
        endcase
      end
    end
  end

  // sticky status flags, a set wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      errFlag  <= 1'b0;
      doneFlag <= 1'b0;
    end else begin
      if (stb.reject)                 errFlag <= 1'b1;
      else if (statWr && regWdata[0]) errFlag <= 1'b0;
      if (stb.finish)                  doneFlag <= 1'b1;
      else if (statWr && regWdata[30]) doneFlag <= 1'b0;
    end
  end

  // working pointers, word counter and data holding register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcCur    <= '0;
      dstCur    <= '0;
      remaining <= '0;
      dataBuf   <= '0;
    end else if (stb.loadPtrs) begin
      srcCur    <= {srcHi, srcLo};
      dstCur    <= {dstHi, dstLo};
      remaining <= wordCnt;
      dataBuf   <= patReg;
    end else begin
      if (stb.captureRd) dataBuf <= memRdata;
      if (stb.stepWord) begin
        srcCur    <= srcCur + STEP;
        dstCur    <= dstCur + STEP;
        remaining <= remaining - 1'b1;
      end
    end
  end

  assign memAddr  = memWrite ? dstCur : srcCur;
  assign memWdata = dataBuf;
  assign irq      = doneFlag && ctrlReg[BIT_IRQEN];

  always_comb begin
    case (regAddr)
      OFS_CTRL: regRdata = ctrlReg;
      OFS_STAT: regRdata = {busy, doneFlag, 29'd0, errFlag};
      OFS_SRC:  regRdata = srcLo;
      OFS_DST:  regRdata = dstLo;
      OFS_HI:   regRdata = {8'd0, dstHi, 8'd0, srcHi};
      OFS_CNT:  regRdata = {{PAD_W{1'b0}}, wordCnt};
      OFS_PAT:  regRdata = patReg;
      OFS_ACC:  regRdata = {30'd0, accessReg};
      default:  regRdata = '0;
    endcase
  end

  // R10: address and data held while the memory stalls
  a_r10_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !memReady && !stopReq) |=> ($stable(memAddr) && $stable(memWdata)));

  // R4: the controller never steps past the final word
  a_r4_no_overstep: assert property (@(posedge clk) disable iff (!rstN)
    stb.stepWord |-> (remaining != '0));
endmodule

// File: rtl/cpfill_dma.sv
module cpfill_dma
  import cpfill_pkg::*;
#(
  parameter int CNT_W = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [7:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              memReq,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memReady,
  output logic              irq
);
  dpStrobe_t stb;
  logic goReq, stopReq, accessOpen, lastWord;
  logic [2:0] wrMode;

  cpfill_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .goReq      (goReq),
    .stopReq    (stopReq),
    .wrMode     (wrMode),
    .accessOpen (accessOpen),
    .lastWord   (lastWord),
    .memReady   (memReady),
    .stb        (stb),
    .memReq     (memReq),
    .memWrite   (memWrite)
  );

  cpfill_dpath #(.CNT_W(CNT_W)) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .regWr      (regWr),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .stb        (stb),
    .busy       (memReq),
    .memWrite   (memWrite),
    .memReady   (memReady),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .irq        (irq),
    .goReq      (goReq),
    .stopReq    (stopReq),
    .wrMode     (wrMode),
    .accessOpen (accessOpen),
    .lastWord   (lastWord)
  );
endmodule

// File: tb/cpfill_dma_test.sv
module cpfill_dma_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [7:0]  regAddr = 8'h0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        memReq, memWrite, irq;
  logic [39:0] memAddr;
  logic [31:0] memWdata;
  logic [31:0] memRdata = '0;
  logic        memReady = 1'b0;

  int checks = 0;
  int fails = 0;
  int latency = 1;
  int waitCnt = 0;
  bit stall = 1'b0;
  bit done = 1'b0;

  typedef struct {
    bit          wr;
    logic [39:0] addr;
    logic [31:0] data;
  } memOp_t;
  memOp_t expQ[$];
  logic [31:0] mem [logic [39:0]];

  always #4 clk = ~clk;

  cpfill_dma uut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .memReq(memReq),
    .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memReady(memReady), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // memory model and scoreboard monitor, active on the falling edge
  always @(negedge clk) begin
    memReady = 1'b0;
    if (memReq && !stall && rstN) begin
      waitCnt++;
      if (waitCnt >= latency) begin
        memOp_t e;
        waitCnt  = 0;
        memReady = 1'b1;
        checks++;
        if (expQ.size() == 0) begin
          fails++;
          $display("FAIL R6/R8/R9 unexpected access actual %h expected none", memAddr);
        end else begin
          e = expQ.pop_front();
          if (memWrite !== e.wr || memAddr !== e.addr ||
              (memWrite && memWdata !== e.data)) begin
            fails++;
            $display("FAIL R2/R3/R5 access actual %0b %h %h expected %0b %h %h",
                     memWrite, memAddr, memWdata, e.wr, e.addr, e.data);
          end
        end
        if (memWrite) mem[memAddr] = memWdata;
        else memRdata = mem.exists(memAddr) ? mem[memAddr] : 32'h0;
      end
    end else begin
      waitCnt = 0;
    end
  end

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  function automatic logic [31:0] ctrlVal(input logic [2:0] mode, input bit once,
                                          input bit irqEn);
    return (32'd1 << 31) | (32'(once) << 27) | (32'(mode) << 21) | (32'(irqEn) << 15);
  endfunction

  task automatic waitIdle();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      regRead(8'h04, s);
      if (!s[31]) break;
    end
  endtask

  // driver: programs a job and pushes the expected accesses
  task automatic runJob(input bit fill, input logic [39:0] src, input logic [39:0] dst,
                        input int n, input logic [31:0] pat, input bit once,
                        input bit irqEn, input int lat);
    logic [31:0] s;
    latency = lat;
    regWrite(8'h04, 32'h4000_0001);
    regWrite(8'h38, 32'd0);
    regWrite(8'h34, pat);
    regWrite(8'h0C, src[31:0]);
    regWrite(8'h10, dst[31:0]);
    regWrite(8'h14, {8'd0, dst[39:32], 8'd0, src[39:32]});
    regWrite(8'h20, 32'(n - 1));
    for (int i = 0; i < n; i++) begin
      logic [39:0] sa = src + 40'(4 * i);
      logic [39:0] da = dst + 40'(4 * i);
      logic [31:0] v = 32'hA500_0000 ^ (32'(i) * 32'h0101_0101) ^ src[31:0];
      if (!fill) begin
        mem[sa] = v;
        expQ.push_back('{1'b0, sa, 32'h0});
        expQ.push_back('{1'b1, da, v});
      end else begin
        expQ.push_back('{1'b1, da, pat});
      end
    end
    regWrite(8'h00, ctrlVal(fill ? 3'd6 : 3'd4, once, irqEn));
    regRead(8'h04, s);
    check(s[31] == 1'b1 || expQ.size() == 0, "R11 busy during transfer", s, 32'h8000_0000);
    waitIdle();
    check(expQ.size() == 0, "R4 all words moved", expQ.size(), 0);
    regRead(8'h04, s);
    check(s[31:30] == 2'b01, "R7 busy low, done set", s[31:30], 2'b01);
  endtask

  initial begin
    logic [31:0] r;
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRead(8'h00, r); check(r == 0, "R1 ctrl reset", r, 0);
    regRead(8'h04, r); check(r == 0, "R1 status reset", r, 0);
    regRead(8'h14, r); check(r == 0, "R1 high address reset", r, 0);
    check(memReq == 0 && irq == 0, "R1 outputs idle", {memReq, irq}, 0);

    // R2 R3 copy with carry into the upper address bits, R7 irq
    runJob(1'b0, 40'h12_FFFF_FFF8, 40'h7E_FFFF_FFFC, 4, 32'h0, 1'b1, 1'b1, 1);
    check(irq == 1'b1, "R7 irq raised", irq, 1);
    regRead(8'h00, r); check(r[31] == 1'b0, "R12 run-once clears enable", r[31], 0);
    regWrite(8'h04, 32'h4000_0000);
    #1 check(irq == 1'b0, "R7 irq cleared by status write", irq, 0);
    regRead(8'h04, r); check(r[30] == 1'b0, "R7 done cleared", r[30], 0);

    // R4 single word, slow memory, irq masked
    runJob(1'b0, 40'h00_0000_1000, 40'h01_0000_2000, 1, 32'h0, 1'b1, 1'b0, 3);
    check(irq == 1'b0, "R7 irq masked", irq, 0);

    // R5 fill, R12 without run-once
    runJob(1'b1, 40'h0, 40'h03_0000_4000, 5, 32'hDEAD_BEEF, 1'b0, 1'b0, 2);
    regRead(8'h00, r); check(r[31] == 1'b1, "R12 enable kept", r[31], 1);
    regWrite(8'h00, 32'h0);

    // R6 blocked access
    regWrite(8'h38, 32'd3);
    regWrite(8'h00, ctrlVal(3'd4, 1'b1, 1'b0));
    repeat (8) @(negedge clk);
    check(memReq == 1'b0, "R6 no request when blocked", memReq, 0);
    regRead(8'h04, r); check(r[0] == 1'b1, "R6 error set", r, 1);
    regRead(8'h00, r); check(r[31] == 1'b0, "R6 enable left clear", r[31], 0);
    regWrite(8'h04, 32'h1);
    regRead(8'h04, r); check(r[0] == 1'b0, "R6 error cleared", r[0], 0);
    regWrite(8'h38, 32'd0);

    // R9 unsupported mode
    regWrite(8'h00, ctrlVal(3'd5, 1'b1, 1'b0));
    repeat (4) @(negedge clk);
    check(memReq == 1'b0, "R9 no request for bad mode", memReq, 0);
    regRead(8'h04, r); check(r[0] == 1'b1, "R9 error set", r[0], 1);
    regWrite(8'h04, 32'h1);

    // R8 stop while stalled, R10 hold
    stall = 1'b1;
    regWrite(8'h0C, 32'h0000_8000);
    regWrite(8'h20, 32'd2);
    regWrite(8'h00, ctrlVal(3'd4, 1'b1, 1'b0));
    @(negedge clk);
    r = memAddr[31:0];
    repeat (3) @(negedge clk);
    check(memReq == 1'b1 && memAddr[31:0] == r, "R10 request held", memAddr, r);
    regRead(8'h04, r); check(r[31] == 1'b1, "R11 busy while stalled", r[31], 1);
    regWrite(8'h00, 32'h0);
    check(memReq == 1'b0, "R8 request dropped", memReq, 0);
    regRead(8'h04, r); check(r[31] == 1'b0, "R8 busy cleared", r[31], 0);
    stall = 1'b0;
    repeat (6) @(negedge clk);
    check(memReq == 1'b0, "R8 no further access", memReq, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule